// File: doc/BRIEF.md
# Zero-Overhead Loop Controller

This block sits next to the fetch stage of a small processor and lets a code region repeat with no extra cycles at the point where it wraps. The core programs three registers through a write port: the first address of the body, the address of its last instruction, and the number of loop-backs that remain. While a loop is armed, the block compares each issued fetch address with the end address. On a match with loop-backs left, it drives the body start as the next fetch address in that same cycle and counts down by one. On a match with none left, fetch continues sequentially and the loop ends.

Zero-penalty looping only works for well-formed code. Both addresses must be 8-byte aligned, the body must span at least eight 32-bit instructions, and a 16-bit instruction inside an armed body is illegal. The block rejects or aborts any loop that breaks these rules and raises a sticky error flag. While a loop is armed it asks the interrupt controller to hold interrupts off.

The fetch side is a plain per-cycle strobe with no back-pressure, because the block only watches addresses the fetch stage has already committed to issue. The write port is a single-cycle strobe that is always accepted.

Top module: `zol_ctrl`

## Requirements
- R1: After a synchronous reset, all three registers read as zero, the loop is disarmed, and `irq_mask`, `cfg_err` and `redirect` are low.
- R2: A write with `wr_sel` 0 sets the body start, 1 sets the body end, and 2 sets the count. `wr_sel` 3 changes nothing. Every write takes effect from the cycle after the strobe.
- R3: When `fetch_valid` is high, the loop is armed with a legal configuration, `fetch_addr` equals the end address, the count is nonzero and `fetch_half` is low, then in that same cycle `redirect` is 1 and `next_addr` equals the start address, and the count drops by one.
- R4: In every other cycle `redirect` is 0 and `next_addr` is `fetch_addr` + 4, or `fetch_addr` + 2 when `fetch_half` is 1. A cycle with `fetch_valid` low never redirects or changes the count.
- R5: A fetch of the end address with the count at zero falls through to end + 4, and the loop is disarmed from the next cycle.
- R6: Writing a nonzero count with a legal configuration arms the loop and clears `cfg_err`. Writing zero disarms the loop and clears `cfg_err`.
- R7: A start or end address whose low three bits are not zero is illegal. Writing a nonzero count with it leaves the loop disarmed and sets `cfg_err`.
- R8: An end minus start of less than 32 bytes, including end at or below start, is illegal and is handled the same way as R7.
- R9: A fetch with `fetch_half` = 1 at an address from start to end inclusive, while armed, gets no redirect. The following cycle shows `cfg_err` = 1 and the loop disarmed. A 16-bit fetch outside the body has no effect.
- R10: `irq_mask` is high exactly while the loop is armed.
- R11: A register write in the same cycle as a loop-back leaves that redirect on the old values. A count write in that cycle overrides the decrement.
- R12: If a start or end write makes an armed loop illegal, no further redirect happens. The loop is disarmed with `cfg_err` set one cycle after the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid | input | 1 | A fetch is issued this cycle |
| fetch_addr | input | 32 | Address of the issued fetch |
| fetch_half | input | 1 | Issued instruction is 16 bits wide |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 start, 1 end, 2 count, 3 no effect |
| wr_data | input | 32 | Write data |
| next_addr | output | 32 | Next fetch address |
| redirect | output | 1 | `next_addr` is a loop-back target |
| irq_mask | output | 1 | Hold interrupts off (loop armed) |
| cfg_err | output | 1 | Sticky illegal-loop flag |

## Verification
The main loop-back path is tried in four ways:
- Fetches from inside the body, which must stay sequential.
- Repeated fetches of the end address as the count runs down, which separates a taken loop-back from the final fall-through.
- End-address fetches with `fetch_valid` low or with a 16-bit instruction, which must neither redirect nor use up a count.
- End-address fetches that coincide with a register write, which show whether the old values or the new ones drive the redirect.

Illegal start/end pairs are tried in three ways: misaligned, too short, and made illegal while armed. Each must show up on `cfg_err` with no redirect.

// File: rtl/zol_pkg.sv
package zol_pkg;
  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_END   = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_NONE  = 2'd3
  } zol_sel_e;
endpackage

// File: rtl/zol_cfg_check.sv
module zol_cfg_check #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 3,
  parameter int MIN_SPAN   = 32
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  output logic              cfg_ok
);
  localparam logic [ADDR_W-1:0] MIN_SPAN_V = ADDR_W'(MIN_SPAN);

  logic [ADDR_W:0] span;
  logic            aligned;
  logic            long_enough;

  assign span = {1'b0, end_addr} - {1'b0, start_addr};

  generate
    if (ALIGN_BITS > 0) begin : g_align
      assign aligned = ~|start_addr[ALIGN_BITS-1:0] & ~|end_addr[ALIGN_BITS-1:0];
    end else begin : g_noalign
      assign aligned = 1'b1;
    end
  endgenerate

  assign long_enough = !span[ADDR_W] && (span[ADDR_W-1:0] >= MIN_SPAN_V);
  assign cfg_ok      = aligned && long_enough;
endmodule

// File: rtl/zol_match.sv
module zol_match #(
  parameter int ADDR_W     = 32,
  parameter int FULL_BYTES = 4,
  parameter int HALF_BYTES = 2
) (
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_half,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic              count_nz,
  input  logic              active,
  input  logic              cfg_ok,
  output logic              take_back,
  output logic              final_pass,
  output logic              short_viol,
  output logic [ADDR_W-1:0] next_addr
);
  localparam logic [ADDR_W-1:0] STEP_FULL = ADDR_W'(FULL_BYTES);
  localparam logic [ADDR_W-1:0] STEP_HALF = ADDR_W'(HALF_BYTES);

  logic              in_body;
  logic              at_end;
  logic [ADDR_W-1:0] seq_addr;

  assign in_body    = (fetch_addr >= start_addr) && (fetch_addr <= end_addr);
  assign at_end     = fetch_valid && active && cfg_ok && (fetch_addr == end_addr);
  assign short_viol = fetch_valid && active && fetch_half && in_body;
  assign take_back  = at_end && count_nz && !fetch_half;
  assign final_pass = at_end && !count_nz && !fetch_half;
  assign seq_addr   = fetch_addr + (fetch_half ? STEP_HALF : STEP_FULL);
  assign next_addr  = take_back ? start_addr : seq_addr;
endmodule

// File: rtl/zol_state.sv
module zol_state
  import zol_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  zol_sel_e          wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              take_back,
  input  logic              final_pass,
  input  logic              short_viol,
  input  logic              cfg_ok,
  output logic [ADDR_W-1:0] start_q,
  output logic [ADDR_W-1:0] end_q,
  output logic [CNT_W-1:0]  count_q,
  output logic              active_q,
  output logic              err_q
);
  logic wr_start, wr_end, wr_count, data_nz;

  assign wr_start = wr_en && (wr_sel == SEL_START);
  assign wr_end   = wr_en && (wr_sel == SEL_END);
  assign wr_count = wr_en && (wr_sel == SEL_COUNT);
  assign data_nz  = |wr_data[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      end_q   <= '0;
    end else begin
      if (wr_start) start_q <= wr_data;
      if (wr_end)   end_q   <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            count_q <= '0;
    else if (wr_count)  count_q <= wr_data[CNT_W-1:0];
    else if (take_back) count_q <= count_q - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      err_q    <= 1'b0;
    end else if (wr_count) begin
      active_q <= data_nz && cfg_ok;
      err_q    <= data_nz && !cfg_ok;
    end else if (active_q && (short_viol || !cfg_ok)) begin
      active_q <= 1'b0;
      err_q    <= 1'b1;
    end else if (final_pass) begin
      active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl
  import zol_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int CNT_W         = 32,
  parameter int ALIGN_BYTES   = 8,
  parameter int INSN_BYTES    = 4,
  parameter int MIN_BODY_INSN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_half,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] next_addr,
  output logic              redirect,
  output logic              irq_mask,
  output logic              cfg_err
);
  localparam int ALIGN_BITS = $clog2(ALIGN_BYTES);
  localparam int MIN_SPAN   = MIN_BODY_INSN * INSN_BYTES;
  localparam int HALF_BYTES = INSN_BYTES / 2;

  logic [ADDR_W-1:0] start_q, end_q;
  logic [CNT_W-1:0]  count_q;
  logic              active_q, err_q, cfg_ok;
  logic              take_back, final_pass, short_viol;

  zol_cfg_check #(
    .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS), .MIN_SPAN(MIN_SPAN)
  ) u_cfg (
    .start_addr(start_q), .end_addr(end_q), .cfg_ok(cfg_ok)
  );

  zol_match #(
    .ADDR_W(ADDR_W), .FULL_BYTES(INSN_BYTES), .HALF_BYTES(HALF_BYTES)
  ) u_match (
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_half(fetch_half),
    .start_addr(start_q), .end_addr(end_q), .count_nz(|count_q),
    .active(active_q), .cfg_ok(cfg_ok),
    .take_back(take_back), .final_pass(final_pass), .short_viol(short_viol),
    .next_addr(next_addr)
  );

  zol_state #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_state (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(zol_sel_e'(wr_sel)),
    .wr_data(wr_data), .take_back(take_back), .final_pass(final_pass),
    .short_viol(short_viol), .cfg_ok(cfg_ok),
    .start_q(start_q), .end_q(end_q), .count_q(count_q),
    .active_q(active_q), .err_q(err_q)
  );

  assign redirect = take_back;
  assign irq_mask = active_q;
  assign cfg_err  = err_q;
endmodule

// File: rtl/zol_ctrl_chk.sv
module zol_ctrl_chk #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 32,
  parameter int ALIGN_BITS = 3,
  parameter int MIN_SPAN   = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              fetch_half,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [ADDR_W-1:0] next_addr,
  input logic              redirect,
  input logic              irq_mask,
  input logic              cfg_err,
  input logic [ADDR_W-1:0] end_q,
  input logic [CNT_W-1:0]  count_q
);
  localparam logic [ADDR_W-1:0] MIN_SPAN_V = ADDR_W'(MIN_SPAN);

  a_r3_back_decrements: assert property (@(posedge clk) disable iff (rst)
    (redirect && !(wr_en && wr_sel == 2'd2)) |=> (count_q == $past(count_q) - CNT_W'(1)));

  a_r10_redirect_masked: assert property (@(posedge clk) disable iff (rst)
    redirect |-> irq_mask);

  a_r7_target_aligned: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (next_addr[ALIGN_BITS-1:0] == '0));

  a_r8_body_long: assert property (@(posedge clk) disable iff (rst)
    redirect |-> ((fetch_addr - next_addr) >= MIN_SPAN_V && fetch_addr > next_addr));

  a_r5_exit_disarms: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && irq_mask && !fetch_half && fetch_addr == end_q && count_q == '0 && !wr_en)
    |=> !irq_mask);

  a_r9_half_no_redirect: assert property (@(posedge clk) disable iff (rst)
    fetch_half |-> !redirect);

  a_r6_err_disarmed: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !irq_mask);

  a_r4_idle_no_redirect: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |-> !redirect);
endmodule

bind zol_ctrl zol_ctrl_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .ALIGN_BITS(ALIGN_BITS), .MIN_SPAN(MIN_SPAN)
) u_chk (
  .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
  .fetch_half(fetch_half), .wr_en(wr_en), .wr_sel(wr_sel), .next_addr(next_addr),
  .redirect(redirect), .irq_mask(irq_mask), .cfg_err(cfg_err),
  .end_q(end_q), .count_q(count_q)
);

// File: tb/zol_ctrl_tb.sv
module zol_ctrl_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        fetch_valid, fetch_half, wr_en;
  logic [31:0] fetch_addr, wr_data, next_addr;
  logic [1:0]  wr_sel;
  logic        redirect, irq_mask, cfg_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  zol_ctrl u_dut (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_half(fetch_half), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .next_addr(next_addr), .redirect(redirect), .irq_mask(irq_mask), .cfg_err(cfg_err)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    @(negedge clk);
    fetch_valid = 0; fetch_half = 0; fetch_addr = 32'h0;
    wr_en = 0; wr_sel = 2'd0; wr_data = 32'h0;
  endtask

  task automatic write_reg(logic [1:0] sel, logic [31:0] data);
    @(negedge clk);
    fetch_valid = 0; wr_en = 1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic program_loop(logic [31:0] s, logic [31:0] e, logic [31:0] c);
    write_reg(2'd0, s);
    write_reg(2'd1, e);
    write_reg(2'd2, c);
  endtask

  // one fetch, optional concurrent write; checks the same-cycle outputs
  task automatic fetch(string tag, logic [31:0] addr, logic half, logic valid,
                       logic wr, logic [1:0] sel, logic [31:0] data,
                       logic exp_redir, logic [31:0] exp_next);
    @(negedge clk);
    fetch_valid = valid; fetch_addr = addr; fetch_half = half;
    wr_en = wr; wr_sel = sel; wr_data = data;
    #1;
    check({tag, " redirect"}, 32'(redirect), 32'(exp_redir));
    check({tag, " next_addr"}, next_addr, exp_next);
  endtask

  task automatic check_flags(string tag, logic exp_mask, logic exp_err);
    #1;
    check({tag, " irq_mask"}, 32'(irq_mask), 32'(exp_mask));
    check({tag, " cfg_err"}, 32'(cfg_err), 32'(exp_err));
  endtask

  task automatic t_reset();
    rst = 1;
    quiet(); quiet();
    rst = 0;
    quiet();
    check_flags("R1 reset", 0, 0);
    fetch("R1 reset fetch at 0", 32'h0, 0, 1, 0, 0, 0, 0, 32'h4);
    quiet();
  endtask

  task automatic t_basic();
    program_loop(32'h100, 32'h120, 32'd2);
    check_flags("R6 armed", 1, 0);
    fetch("R4 body", 32'h100, 0, 1, 0, 0, 0, 0, 32'h104);
    fetch("R4 before end", 32'h11C, 0, 1, 0, 0, 0, 0, 32'h120);
    fetch("R3 first back", 32'h120, 0, 1, 0, 0, 0, 1, 32'h100);
    fetch("R3 second back", 32'h120, 0, 1, 0, 0, 0, 1, 32'h100);
    check_flags("R10 still armed", 1, 0);
    fetch("R5 fall through", 32'h120, 0, 1, 0, 0, 0, 0, 32'h124);
    quiet();
    check_flags("R5 disarmed", 0, 0);
    fetch("R5 no back after exit", 32'h120, 0, 1, 0, 0, 0, 0, 32'h124);
    quiet();
  endtask

  task automatic t_zero_count();
    program_loop(32'h100, 32'h120, 32'd3);
    write_reg(2'd2, 32'd0);
    check_flags("R6 zero disarms", 0, 0);
    fetch("R6 zero no back", 32'h120, 0, 1, 0, 0, 0, 0, 32'h124);
    quiet();
  endtask

  task automatic t_short_body();
    program_loop(32'h100, 32'h118, 32'd1);
    check_flags("R8 short body", 0, 1);
    fetch("R8 short no back", 32'h118, 0, 1, 0, 0, 0, 0, 32'h11C);
    program_loop(32'h140, 32'h100, 32'd1);
    check_flags("R8 end below start", 0, 1);
    quiet();
  endtask

  task automatic t_misalign();
    program_loop(32'h104, 32'h140, 32'd1);
    check_flags("R7 start misaligned", 0, 1);
    program_loop(32'h100, 32'h13C, 32'd1);
    check_flags("R7 end misaligned", 0, 1);
    write_reg(2'd1, 32'h140);
    write_reg(2'd2, 32'd1);
    check_flags("R6 rearm clears err", 1, 0);
    fetch("R3 back after fix", 32'h140, 0, 1, 0, 0, 0, 1, 32'h100);
    fetch("R5 drain", 32'h140, 0, 1, 0, 0, 0, 0, 32'h144);
    quiet();
  endtask

  task automatic t_half();
    program_loop(32'h100, 32'h120, 32'd5);
    fetch("R9 half outside", 32'h200, 1, 1, 0, 0, 0, 0, 32'h202);
    check_flags("R9 outside harmless", 1, 0);
    fetch("R9 half at end", 32'h120, 1, 1, 0, 0, 0, 0, 32'h122);
    quiet();
    check_flags("R9 abort", 0, 1);
    fetch("R9 no back after abort", 32'h120, 0, 1, 0, 0, 0, 0, 32'h124);
    quiet();
  endtask

  task automatic t_write_overlap();
    program_loop(32'h100, 32'h120, 32'd3);
    fetch("R11 old start used", 32'h120, 0, 1, 1, 2'd0, 32'h0C0, 1, 32'h100);
    fetch("R11 new start next", 32'h120, 0, 1, 0, 0, 0, 1, 32'h0C0);
    fetch("R11 count write with back", 32'h120, 0, 1, 1, 2'd2, 32'd0, 1, 32'h0C0);
    quiet();
    check_flags("R11 count write wins", 0, 0);
    quiet();
  endtask

  task automatic t_reserved();
    program_loop(32'h100, 32'h120, 32'd1);
    write_reg(2'd3, 32'h0);
    check_flags("R2 sel3 no effect", 1, 0);
    fetch("R2 sel3 count kept", 32'h120, 0, 1, 0, 0, 0, 1, 32'h100);
    fetch("R2 sel3 start kept", 32'h120, 0, 1, 0, 0, 0, 0, 32'h124);
    quiet();
  endtask

  task automatic t_valid_gate();
    program_loop(32'h100, 32'h120, 32'd1);
    fetch("R4 invalid at end", 32'h120, 0, 0, 0, 0, 0, 0, 32'h124);
    fetch("R4 count not used", 32'h120, 0, 1, 0, 0, 0, 1, 32'h100);
    fetch("R5 then exit", 32'h120, 0, 1, 0, 0, 0, 0, 32'h124);
    quiet();
  endtask

  task automatic t_invalidate();
    program_loop(32'h100, 32'h120, 32'd4);
    write_reg(2'd1, 32'h110);
    fetch("R12 no back on bad cfg", 32'h110, 0, 1, 0, 0, 0, 0, 32'h114);
    quiet();
    check_flags("R12 abort", 0, 1);
    quiet();
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; fetch_valid = 0; fetch_half = 0; fetch_addr = 0;
    wr_en = 0; wr_sel = 0; wr_data = 0;
    t_reset();
    t_basic();
    t_zero_count();
    t_short_body();
    t_misalign();
    t_half();
    t_write_overlap();
    t_reserved();
    t_valid_gate();
    t_invalidate();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule